// File: doc/BRIEF.md
# LSB-First Chainable Serial Slave Port

This block is the device side of a chip-select-framed synchronous serial link. It runs entirely in the system clock domain. The serial chip select, serial clock and data input are brought in through synchronizers, and their edges are found by oversampling. The system clock must run at least eight times faster than the serial clock.

Each frame carries one 16-bit word in each direction, bit 0 first. When chip select falls, the block loads a snapshot of its parallel status word into a shift register. It puts status bit 0 on the data output at once, before any serial clock edge arrives. On every falling serial clock edge the data input is shifted in. On every rising edge the data output moves to the next bit. While chip select is high, the data output enable is low so that several devices can share one return line. Because the shift chain is continuous, the bits received on the data input reappear on the data output once the 16 status bits have been sent. This allows devices to be chained.

When chip select rises, the received word is published as a parallel command with a one-cycle strobe, but only if the frame held exactly 16 falling clock edges. Any other frame is dropped. What the command bits mean is decided by the logic that consumes them.

Top module: `serial_chain_slave`

## Requirements
- R1: While reset is active and after it is released, `sdo_oe_o` is 0, `cmd_valid_o` is 0 and `cmd_o` is all zeros.
- R2: `sdo_oe_o` goes to 1 within a few system cycles of `cs_n_i` falling. It returns to 0 within a few cycles of `cs_n_i` rising, and stays 0 while `cs_n_i` is high.
- R3: `status_i` is sampled when `cs_n_i` falls. Bit 0 of that sample is on `sdo_o` before the first serial clock edge. Changes to `status_i` later in the frame have no effect on `sdo_o`.
- R4: `sdo_o` changes only after a rising `sclk_i` edge or a falling `cs_n_i` edge. After the k-th rising edge of the frame (k counted from 1, for k up to 16), `sdo_o` carries captured status bit k-1.
- R5: `sdi_i` is sampled on each falling `sclk_i` edge, least significant bit first. The value sampled at the n-th falling edge (n counted from 1) becomes bit n-1 of `cmd_o`.
- R6: `cmd_valid_o` pulses high for exactly one system cycle after `cs_n_i` rises, and only for a frame with exactly 16 falling clock edges. `cmd_o` is updated in that same cycle.
- R7: A frame with any number of falling clock edges other than 16 (including 0 and more than 16) produces no strobe and leaves `cmd_o` unchanged.
- R8: In a frame longer than 16 clocks, after the rising edge numbered 16+j (for j from 1 upward), `sdo_o` carries the `sdi_i` value sampled at falling edge j of the same frame.
- R9: Between strobes, `cmd_o` holds its value.
- R10: Serial clock edges while `cs_n_i` is high shift nothing, produce no strobe and leave `cmd_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n_i | input | 1 | Active-low frame select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in, bit 0 first |
| status_i | input | 16 | Parallel status word loaded at frame start |
| sdo_o | output | 1 | Serial data out, bit 0 first |
| sdo_oe_o | output | 1 | Output enable for the shared data line pad (1 = drive) |
| cmd_o | output | 16 | Last accepted command word |
| cmd_valid_o | output | 1 | One-cycle strobe marking a new command word |

## Verification
The hardest case to reach is the daisy-chain turnaround. Bits received in the current frame must reach the output only after the 16th rising edge. This requires a frame longer than the native word, and such a frame must then be discarded at its end. The stimulus drives a 32-clock frame with distinct upper and lower data halves. It checks every output bit after every rising edge, then confirms that no strobe arrives and that the command word is left as it was. Short frames, an empty frame and clock activity while deselected are driven between full frames. This shows that the command only moves on an exact 16-edge frame.

// File: rtl/scs_pkg.sv
package scs_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_ev_t;

  localparam int LANE_CS   = 0;
  localparam int LANE_SCLK = 1;
  localparam int LANE_SDI  = 2;
  localparam int NUM_LANES = 3;

endpackage

// File: rtl/scs_rst_sync.sv
module scs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/scs_sync_lane.sv
module scs_sync_lane #(
  parameter int   STAGES  = 2,
  parameter logic IDLE_LV = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  always_comb begin
    ff_d = {ff_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= {STAGES{IDLE_LV}};
    end else begin
      ff_q <= ff_d;
    end
  end

  assign sync_o = ff_q[STAGES-1];

endmodule

// File: rtl/scs_edge_det.sv
module scs_edge_det
  import scs_pkg::*;
#(
  parameter logic IDLE_LV = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     level_i,
  output edge_ev_t ev_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE_LV;
    end else begin
      prev_q <= level_i;
    end
  end

  always_comb begin
    ev_o.rise = level_i & ~prev_q;
    ev_o.fall = ~level_i & prev_q;
  end

endmodule

// File: rtl/scs_frame_engine.sv
module scs_frame_engine
  import scs_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  edge_ev_t          cs_ev_i,
  input  edge_ev_t          sclk_ev_i,
  input  logic              sdi_i,
  input  logic [WORD_W-1:0] status_i,
  output logic              sdo_o,
  output logic              oe_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic              cmd_valid_o
);

  localparam int               CNT_W    = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

  logic              active_q, active_d;
  logic [CNT_W-1:0]  cnt_q,    cnt_d;
  logic [WORD_W-1:0] shreg_q,  shreg_d;
  logic              sdo_q,    sdo_d;
  logic [WORD_W-1:0] cmd_q,    cmd_d;
  logic              vld_q,    vld_d;

  logic cs_fall, cs_rise, sc_fall, sc_rise;
  logic load_en, end_en, shift_en, drive_en;

  assign cs_fall = cs_ev_i.fall;
  assign cs_rise = cs_ev_i.rise;
  assign sc_fall = sclk_ev_i.fall;
  assign sc_rise = sclk_ev_i.rise;

  // explicit enables per action
  assign load_en  = cs_fall;
  assign end_en   = cs_rise & active_q;
  assign shift_en = active_q & ~cs_rise & ~cs_fall & sc_fall;
  assign drive_en = active_q & ~cs_rise & ~cs_fall & sc_rise;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    shreg_d  = shreg_q;
    sdo_d    = sdo_q;
    cmd_d    = cmd_q;
    vld_d    = 1'b0;

    if (load_en) begin
      active_d = 1'b1;
      cnt_d    = '0;
      shreg_d  = status_i;
      sdo_d    = status_i[0];
    end else if (end_en) begin
      active_d = 1'b0;
      if (cnt_q == CNT_FULL) begin
        cmd_d = shreg_q;
        vld_d = 1'b1;
      end
    end else if (shift_en) begin
      shreg_d = {sdi_i, shreg_q[WORD_W-1:1]};
      if (cnt_q != CNT_SAT) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else if (drive_en) begin
      sdo_d = shreg_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      sdo_q    <= 1'b0;
      cmd_q    <= '0;
      vld_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      shreg_q  <= shreg_d;
      sdo_q    <= sdo_d;
      cmd_q    <= cmd_d;
      vld_q    <= vld_d;
    end
  end

  assign sdo_o       = active_q ? sdo_q : 1'b0;
  assign oe_o        = active_q;
  assign cmd_o       = cmd_q;
  assign cmd_valid_o = vld_q;

  logic sdo_evt;
  assign sdo_evt = sc_rise | cs_fall;

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R6

  AST_STROBE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> !active_q); // R6

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> $stable(cmd_q)); // R9

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !cs_fall) |=> $stable(shreg_q)); // R10

  AST_SDO_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdo_q) |-> $past(sdo_evt)); // R4

  AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cs_rise) |=> !active_q); // R2

endmodule

// File: rtl/serial_chain_slave.sv
module serial_chain_slave
  import scs_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [WORD_W-1:0] status_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [WORD_W-1:0] cmd_o,
  output logic              cmd_valid_o
);

  localparam logic [NUM_LANES-1:0] LANE_IDLE = NUM_LANES'(1) << LANE_CS;

  logic                 rst_n_core;
  logic [NUM_LANES-1:0] raw_lanes;
  logic [NUM_LANES-1:0] syn_lanes;
  edge_ev_t             cs_ev;
  edge_ev_t             sclk_ev;

  scs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_core)
  );

  assign raw_lanes[LANE_CS]   = cs_n_i;
  assign raw_lanes[LANE_SCLK] = sclk_i;
  assign raw_lanes[LANE_SDI]  = sdi_i;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    scs_sync_lane #(
      .STAGES  (SYNC_STAGES),
      .IDLE_LV (LANE_IDLE[g])
    ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n_core),
      .async_i (raw_lanes[g]),
      .sync_o  (syn_lanes[g])
    );
  end

  scs_edge_det #(.IDLE_LV(1'b1)) u_cs_edge (
    .clk     (clk),
    .rst_n   (rst_n_core),
    .level_i (syn_lanes[LANE_CS]),
    .ev_o    (cs_ev)
  );

  scs_edge_det #(.IDLE_LV(1'b0)) u_sclk_edge (
    .clk     (clk),
    .rst_n   (rst_n_core),
    .level_i (syn_lanes[LANE_SCLK]),
    .ev_o    (sclk_ev)
  );

  scs_frame_engine #(.WORD_W(WORD_W)) u_engine (
    .clk         (clk),
    .rst_n       (rst_n_core),
    .cs_ev_i     (cs_ev),
    .sclk_ev_i   (sclk_ev),
    .sdi_i       (syn_lanes[LANE_SDI]),
    .status_i    (status_i),
    .sdo_o       (sdo_o),
    .oe_o        (sdo_oe_o),
    .cmd_o       (cmd_o),
    .cmd_valid_o (cmd_valid_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n_core |-> (!sdo_oe_o && !cmd_valid_o)); // R1

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n_core)
    (syn_lanes[LANE_CS] && $past(syn_lanes[LANE_CS])) |-> !sdo_oe_o); // R2

endmodule

// File: tb/serial_chain_slave_tb_top.sv
module serial_chain_slave_tb_top;

  localparam int W    = 16;
  localparam int HALF = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cs_n, sclk, sdi;
  logic [W-1:0] status;
  logic         sdo, sdo_oe, cmd_valid;
  logic [W-1:0] cmd;

  int           checks  = 0;
  int           fails   = 0;
  int           strobes = 0;
  int           wd_cnt  = 0;
  bit           done    = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_cmd;

  always #5 clk = ~clk;

  serial_chain_slave #(.WORD_W(W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_i      (cs_n),
    .sclk_i      (sclk),
    .sdi_i       (sdi),
    .status_i    (status),
    .sdo_o       (sdo),
    .sdo_oe_o    (sdo_oe),
    .cmd_o       (cmd),
    .cmd_valid_o (cmd_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on each strobe
  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      strobes++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", {16'h0, cmd}, 32'h0);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(cmd == e, "R5", {16'h0, cmd}, {16'h0, e});
      end
    end
  end

  always @(negedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd_cnt, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_frame(input logic [31:0] di, input logic [W-1:0] st, input int nbits);
    int s0;
    logic eb;
    s0 = strobes;
    status = st;
    cs_n = 1'b0;
    wait_cyc(8);
    chk(sdo_oe == 1'b1, "R2", {31'h0, sdo_oe}, 32'h1);
    chk(sdo == st[0], "R3", {31'h0, sdo}, {31'h0, st[0]});
    status = ~st;  // must not disturb the frame
    for (int i = 0; i < nbits; i++) begin
      sdi  = di[i];
      sclk = 1'b1;
      wait_cyc(HALF);
      if (i < W) begin
        eb = st[i];
        chk(sdo == eb, "R4", {31'h0, sdo}, {31'h0, eb});
      end else begin
        eb = di[i-W];
        chk(sdo == eb, "R8", {31'h0, sdo}, {31'h0, eb});
      end
      sclk = 1'b0;
      wait_cyc(HALF);
    end
    if (nbits == W) exp_q.push_back(di[W-1:0]);
    cs_n = 1'b1;
    wait_cyc(8);
    chk(sdo_oe == 1'b0, "R2", {31'h0, sdo_oe}, 32'h0);
    if (nbits == W) begin
      chk(cmd == di[W-1:0], "R5", {16'h0, cmd}, {16'h0, di[W-1:0]});
      chk(strobes == s0 + 1, "R6", strobes, s0 + 1);
      last_cmd = di[W-1:0];
    end else begin
      chk(cmd == last_cmd, "R7", {16'h0, cmd}, {16'h0, last_cmd});
      chk(strobes == s0, "R7", strobes, s0);
    end
    wait_cyc(4);
    chk(cmd == last_cmd, "R9", {16'h0, cmd}, {16'h0, last_cmd});
  endtask

  initial begin
    rst_n    = 1'b0;
    cs_n     = 1'b1;
    sclk     = 1'b0;
    sdi      = 1'b0;
    status   = 16'h0;
    last_cmd = 16'h0;
    wait_cyc(4);
    chk(sdo_oe == 1'b0, "R1", {31'h0, sdo_oe}, 32'h0);
    chk(cmd_valid == 1'b0, "R1", {31'h0, cmd_valid}, 32'h0);
    rst_n = 1'b1;
    wait_cyc(6);
    chk(cmd == 16'h0, "R1", {16'h0, cmd}, 32'h0);
    chk(sdo_oe == 1'b0, "R1", {31'h0, sdo_oe}, 32'h0);

    run_frame(32'h0000_A5C3, 16'h1234, 16);
    run_frame(32'h0000_8001, 16'hFFFE, 16);
    run_frame(32'h0000_00FF, 16'h5A5A, 8);       // short frame
    run_frame(32'h3C96_6E17, 16'hC0DE, 32);      // daisy-chain length
    run_frame(32'h0, 16'h0F0F, 0);               // empty frame

    // clock activity while deselected
    begin
      int s0;
      s0 = strobes;
      for (int k = 0; k < 6; k++) begin
        sdi  = k[0];
        sclk = 1'b1;
        wait_cyc(HALF);
        chk(sdo_oe == 1'b0, "R10", {31'h0, sdo_oe}, 32'h0);
        sclk = 1'b0;
        wait_cyc(HALF);
      end
      wait_cyc(6);
      chk(strobes == s0, "R10", strobes, s0);
      chk(cmd == last_cmd, "R10", {16'h0, cmd}, {16'h0, last_cmd});
    end

    run_frame(32'h0000_6B1D, 16'h8421, 16);
    wait_cyc(6);
    chk(exp_q.size() == 0, "R6", exp_q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule